// File: doc/BRIEF.md
# Serial Audio Output Formatter With Last-Valid Hold

This block runs from a master clock at 512 times the audio sample rate. It derives a word-select clock and a bit clock from that master clock and shifts out one left and one right 24-bit sample per frame on a single serial data line. The line format is I2S-compatible. Each 24-bit word carries 20 audio bits in bits [23:4] and 4 auxiliary bits in bits [3:0]. Bit 23 is sent first.

Each channel has its own input word, a load strobe and a validity flag. When a load arrives with the validity flag set, the word is kept in that channel's holding register. When a load arrives flagged invalid, the holding register is left alone, so the last valid word for that channel goes out again. The holding register moves into the output shifter only at the word-select edge that opens the channel's slot. A later load therefore never disturbs a word that is already being sent.

A small state machine sequences each 32-bit slot through three states:
- ST_LEAD: the one bit period of delay.
- ST_DATA: the 24 word bits.
- ST_PAD: the remaining 7 bit periods, driven low.

Its transitions are:
- LEAD_TO_DATA: at the end of the lead bit.
- DATA_TO_PAD: at the end of the 24th word bit.
- PAD_TO_LEAD: at the end of the slot.
- Any state goes to ST_LEAD when a slot ends.

Top module: `i2s_out_fmt`

## Requirements
- R1: `lrclk` is the master clock divided by 512. It is high for the left slot and low for the right slot. It changes only in the master-clock cycle where `bclk` falls.
- R2: `bclk` is the master clock divided by 8. Within each 8-cycle bit period it is low for the first 4 master cycles and high for the last 4.
- R3: `sdata` changes only in master cycles where `bclk` falls, so it is stable around every rising edge of `bclk`.
- R4: In each slot, bit periods 1 to 24 (counting from 0 at the `lrclk` edge) carry word bits 23 down to 0, most significant first.
- R5: Bit period 0 and bit periods 25 to 31 of every slot drive `sdata` low.
- R6: A load with the validity flag at 1 stores the word for that channel. A load with the flag at 0 is ignored, and the channel's next slot repeats the last valid word.
- R7: The holding register is copied into the shifter at the master edge that starts the channel's slot. A load during a slot changes nothing in that slot and takes effect in the next slot of that channel.
- R8: After reset both held words are zero, `lrclk` is high (left slot), `bclk` is low, `sdata` is low, and all dividers start from zero. The first left slot therefore sends all zeros.
- R9: The two channels are independent. A load on one channel, valid or not, never changes what the other channel sends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master clock, 512 x sample rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| left_word | input | 24 | Left sample: audio [23:4], auxiliary [3:0] |
| left_valid | input | 1 | Left sample validity flag |
| left_load | input | 1 | Left sample load strobe, one master cycle |
| right_word | input | 24 | Right sample: audio [23:4], auxiliary [3:0] |
| right_valid | input | 1 | Right sample validity flag |
| right_load | input | 1 | Right sample load strobe, one master cycle |
| lrclk | output | 1 | Word-select clock, high = left |
| bclk | output | 1 | Bit clock, 64 x sample rate |
| sdata | output | 1 | Serial data, MSB first, one-bit delay |

## Verification
The bench sends a walking one and its complement through both channels and compares every bit of every slot against an arithmetic model of the frame. A design that misplaced the one-bit delay, reversed the bit order or let pad bits leak data would fail at the exact bit period concerned.

Three kinds of load are aimed at specific corner cases:
- Loads placed mid-slot catch a design that overwrites the word in flight.
- Loads flagged invalid catch a design that lets invalid samples through instead of repeating the last valid word.
- Loads on one channel next to loads on the other catch a design that crosses the two holding registers.

The reset slot is checked to carry zeros. The bench also flags any data or word-select change that is not aligned to a falling bit-clock edge.

// File: rtl/i2s_out_pkg.sv
package i2s_out_pkg;
    typedef enum logic [1:0] {
        ST_LEAD = 2'd0,
        ST_DATA = 2'd1,
        ST_PAD  = 2'd2
    } slot_state_e;
endpackage

// File: rtl/i2s_out_clkgen.sv
module i2s_out_clkgen #(
    parameter int MCLK_DIV  = 8,
    parameter int SLOT_BITS = 32
) (
    input  logic mclk,
    input  logic rst_n,
    output logic bit_end,
    output logic slot_end,
    output logic chan,
    output logic bclk,
    output logic lrclk
);
    localparam int PH_W  = $clog2(MCLK_DIV);
    localparam int BIT_W = $clog2(SLOT_BITS);
    localparam logic [PH_W-1:0]  PH_LAST  = PH_W'(MCLK_DIV - 1);
    localparam logic [PH_W-1:0]  PH_HALF  = PH_W'(MCLK_DIV / 2);
    localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(SLOT_BITS - 1);

    logic [PH_W-1:0]  phase_q;
    logic [BIT_W-1:0] bit_q;
    logic             chan_q;

    always_ff @(posedge mclk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= '0;
            bit_q   <= '0;
            chan_q  <= 1'b0;
        end else if (phase_q == PH_LAST) begin
            phase_q <= '0;
            if (bit_q == BIT_LAST) begin
                bit_q  <= '0;
                chan_q <= ~chan_q;
            end else begin
                bit_q <= bit_q + 1'b1;
            end
        end else begin
            phase_q <= phase_q + 1'b1;
        end
    end

    always_comb begin
        bit_end  = (phase_q == PH_LAST);
        slot_end = bit_end && (bit_q == BIT_LAST);
        chan     = chan_q;
        bclk     = (phase_q >= PH_HALF);
        lrclk    = ~chan_q;
    end
endmodule

// File: rtl/i2s_out_hold.sv
module i2s_out_hold #(
    parameter int W = 24
) (
    input  logic         mclk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         valid,
    input  logic [W-1:0] din,
    output logic [W-1:0] held
);
    always_ff @(posedge mclk or negedge rst_n) begin
        if (!rst_n) begin
            held <= '0;
        end else if (load && valid) begin
            held <= din;
        end
    end
endmodule

// File: rtl/i2s_out_slot.sv
module i2s_out_slot
    import i2s_out_pkg::*;
#(
    parameter int SAMPLE_W  = 24,
    parameter int SLOT_BITS = 32
) (
    input  logic                mclk,
    input  logic                rst_n,
    input  logic                bit_end,
    input  logic                slot_end,
    input  logic [SAMPLE_W-1:0] next_word,
    output slot_state_e         state,
    output logic                sdata
);
    localparam int CNT_W = $clog2(SAMPLE_W);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SAMPLE_W - 1);

    slot_state_e         state_q, state_d;
    logic [SAMPLE_W-1:0] shift_q;
    logic [CNT_W-1:0]    dcnt_q;
    logic                last_bit;

    assign last_bit = (dcnt_q == CNT_LAST);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LEAD: if (bit_end) state_d = ST_DATA;
            ST_DATA: if (bit_end && last_bit) state_d = ST_PAD;
            ST_PAD:  state_d = ST_PAD;
            default: state_d = ST_LEAD;
        endcase
        if (slot_end) state_d = ST_LEAD;
    end

    always_ff @(posedge mclk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_LEAD;
        else        state_q <= state_d;
    end

    always_ff @(posedge mclk or negedge rst_n) begin
        if (!rst_n) begin
            shift_q <= '0;
            dcnt_q  <= '0;
        end else if (slot_end) begin
            shift_q <= next_word;
            dcnt_q  <= '0;
        end else if (state_q == ST_DATA && bit_end) begin
            shift_q <= shift_q << 1;
            dcnt_q  <= dcnt_q + 1'b1;
        end
    end

    always_comb begin
        state = state_q;
        unique case (state_q)
            ST_DATA: sdata = shift_q[SAMPLE_W-1];
            default: sdata = 1'b0;
        endcase
    end
endmodule

// File: rtl/i2s_out_fmt.sv
module i2s_out_fmt
    import i2s_out_pkg::*;
#(
    parameter int SAMPLE_W  = 24,
    parameter int SLOT_BITS = 32,
    parameter int MCLK_DIV  = 8
) (
    input  logic                mclk,
    input  logic                rst_n,
    input  logic [SAMPLE_W-1:0] left_word,
    input  logic                left_valid,
    input  logic                left_load,
    input  logic [SAMPLE_W-1:0] right_word,
    input  logic                right_valid,
    input  logic                right_load,
    output logic                lrclk,
    output logic                bclk,
    output logic                sdata
);
    localparam int NCH = 2;

    logic                bit_end, slot_end, chan;
    logic [NCH-1:0]      ld_v, ok_v;
    logic [SAMPLE_W-1:0] din_a  [NCH];
    logic [SAMPLE_W-1:0] hold_a [NCH];
    logic [SAMPLE_W-1:0] hold_l, hold_r, next_word;
    slot_state_e         slot_state;

    assign ld_v     = {right_load, left_load};
    assign ok_v     = {right_valid, left_valid};
    assign din_a[0] = left_word;
    assign din_a[1] = right_word;
    assign hold_l   = hold_a[0];
    assign hold_r   = hold_a[1];

    i2s_out_clkgen #(.MCLK_DIV(MCLK_DIV), .SLOT_BITS(SLOT_BITS)) u_clk (
        .mclk(mclk), .rst_n(rst_n), .bit_end(bit_end), .slot_end(slot_end),
        .chan(chan), .bclk(bclk), .lrclk(lrclk)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        i2s_out_hold #(.W(SAMPLE_W)) u_hold (
            .mclk(mclk), .rst_n(rst_n), .load(ld_v[g]), .valid(ok_v[g]),
            .din(din_a[g]), .held(hold_a[g])
        );
    end

    // chan = 0 while left is sent; the slot that follows belongs to the other channel
    assign next_word = chan ? hold_l : hold_r;

    i2s_out_slot #(.SAMPLE_W(SAMPLE_W), .SLOT_BITS(SLOT_BITS)) u_slot (
        .mclk(mclk), .rst_n(rst_n), .bit_end(bit_end), .slot_end(slot_end),
        .next_word(next_word), .state(slot_state), .sdata(sdata)
    );
endmodule

// File: rtl/i2s_out_fmt_chk.sv
module i2s_out_fmt_chk
    import i2s_out_pkg::*;
#(
    parameter int W = 24
) (
    input logic        mclk,
    input logic        rst_n,
    input logic        lrclk,
    input logic        bclk,
    input logic        sdata,
    input slot_state_e state,
    input logic        left_load,
    input logic        left_valid,
    input logic        right_load,
    input logic        right_valid,
    input logic [W-1:0] hold_l,
    input logic [W-1:0] hold_r
);
    p_lr_on_fall_r1: assert property (@(posedge mclk) disable iff (!rst_n)
        (lrclk != $past(lrclk)) |-> (!bclk && $past(bclk)));

    p_lr_steady_rise_r2: assert property (@(posedge mclk) disable iff (!rst_n)
        $rose(bclk) |-> $stable(lrclk));

    p_data_on_fall_r3: assert property (@(posedge mclk) disable iff (!rst_n)
        (sdata != $past(sdata)) |-> (!bclk && $past(bclk)));

    p_pad_low_r5: assert property (@(posedge mclk) disable iff (!rst_n)
        (state == ST_LEAD || state == ST_PAD) |-> !sdata);

    p_invalid_left_r6: assert property (@(posedge mclk) disable iff (!rst_n)
        (left_load && !left_valid) |=> (hold_l == $past(hold_l)));

    p_invalid_right_r6: assert property (@(posedge mclk) disable iff (!rst_n)
        (right_load && !right_valid) |=> (hold_r == $past(hold_r)));

    p_left_isolated_r9: assert property (@(posedge mclk) disable iff (!rst_n)
        !right_load && left_load |=> (hold_r == $past(hold_r)));
endmodule

bind i2s_out_fmt i2s_out_fmt_chk #(.W(SAMPLE_W)) u_chk (
    .mclk(mclk), .rst_n(rst_n), .lrclk(lrclk), .bclk(bclk), .sdata(sdata),
    .state(slot_state), .left_load(left_load), .left_valid(left_valid),
    .right_load(right_load), .right_valid(right_valid),
    .hold_l(hold_l), .hold_r(hold_r)
);

// File: tb/i2s_out_fmt_test.sv
`timescale 1ns/1ps
module i2s_out_fmt_test;
    logic        mclk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] lw = '0, rw = '0;
    logic        lv = 1'b0, ll = 1'b0, rv = 1'b0, rl = 1'b0;
    logic        lrclk, bclk, sdata;

    int checks = 0, errors = 0, m = 0, wd = 0;
    logic [23:0] bh_l = '0, bh_r = '0, ew = '0;
    logic [23:0] acc = '0, rx_l = '0, rx_r = '0;
    logic        prev_sd = 1'b0;

    always #10 mclk = ~mclk;

    i2s_out_fmt uut (
        .mclk(mclk), .rst_n(rst_n),
        .left_word(lw), .left_valid(lv), .left_load(ll),
        .right_word(rw), .right_valid(rv), .right_load(rl),
        .lrclk(lrclk), .bclk(bclk), .sdata(sdata)
    );

    task automatic chk(input string tag, input logic [23:0] act, input logic [23:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s m=%0d actual=%h expected=%h", tag, m, act, exp);
        end
    endtask

    // arithmetic model: hold registers, slot word, cycle count since reset release
    always @(posedge mclk) begin
        if (rst_n) begin
            if (ll && lv) bh_l <= lw;
            if (rl && rv) bh_r <= rw;
            if (m % 256 == 255) ew <= (((m + 1) / 256) % 2 == 0) ? bh_l : bh_r;
            m <= m + 1;
        end
    end

    always @(negedge mclk) begin
        if (rst_n) begin
            int p;
            logic exp_sd;
            p = (m / 8) % 32;
            exp_sd = (p >= 1 && p <= 24) ? ew[24 - p] : 1'b0;
            chk("R1 lrclk", {23'd0, lrclk}, {23'd0, ((m / 256) % 2) == 0});
            chk("R2 bclk",  {23'd0, bclk},  {23'd0, (m % 8) >= 4});
            if (p >= 1 && p <= 24) chk("R4 data bit", {23'd0, sdata}, {23'd0, exp_sd});
            else                   chk("R5 pad bit",  {23'd0, sdata}, {23'd0, exp_sd});
            if (m % 8 != 0) chk("R3 sdata stable", {23'd0, sdata}, {23'd0, prev_sd});
            if (m % 8 == 4 && p >= 1 && p <= 24) begin
                acc = {acc[22:0], sdata};
                if (p == 24) begin
                    if ((m / 256) % 2 == 0) rx_l = acc;
                    else                    rx_r = acc;
                end
            end
            prev_sd = sdata;
        end
    end

    always @(posedge mclk) begin
        wd++;
        if (wd > 40000) begin
            errors++;
            $display("FAIL watchdog m=%0d actual=hung expected=done", m);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic wait_m(input int t);
        while (m < t) @(negedge mclk);
    endtask

    task automatic push(input bit ch, input logic [23:0] d, input bit v);
        if (ch) begin rw = d; rv = v; rl = 1'b1; end
        else    begin lw = d; lv = v; ll = 1'b1; end
        @(negedge mclk);
        rl = 1'b0; ll = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge mclk);
        // R8: outputs while reset is held
        chk("R8 reset lrclk", {23'd0, lrclk}, 24'd1);
        chk("R8 reset bclk",  {23'd0, bclk},  24'd0);
        chk("R8 reset sdata", {23'd0, sdata}, 24'd0);
        #2 rst_n = 1'b1;

        wait_m(10);  push(1'b0, 24'hA5C3F1, 1'b1);
        wait_m(12);  push(1'b1, 24'h3C0FF0, 1'b1);
        wait_m(208); chk("R8 first left slot zero", rx_l, 24'h000000);
        wait_m(464); chk("R6 right valid stored", rx_r, 24'h3C0FF0);
        wait_m(600); push(1'b0, 24'h800001, 1'b1);
        wait_m(720); chk("R7 word in flight kept", rx_l, 24'hA5C3F1);
        wait_m(1100); push(1'b0, 24'hFFFFFF, 1'b0);
        wait_m(1232); chk("R7 mid-slot load next slot", rx_l, 24'h800001);
        wait_m(1744); chk("R6 invalid left repeats", rx_l, 24'h800001);
        wait_m(1760); push(1'b1, 24'h123456, 1'b0);
        wait_m(1762); push(1'b0, 24'h000010, 1'b1);
        wait_m(2000); chk("R6 invalid right repeats", rx_r, 24'h3C0FF0);
        wait_m(2256); chk("R9 left independent of right", rx_l, 24'h000010);

        for (int i = 0; i < 24; i++) begin
            int base;
            logic [23:0] one;
            base = 3072 + 512 * i;
            one = 24'h1 << i;
            wait_m(base - 40);  push(1'b0, one, 1'b1);
            wait_m(base + 50);  push(1'b1, ~one, 1'b1);
            wait_m(base + 208); chk("R4 walking left", rx_l, one);
            wait_m(base + 464); chk("R4 walking right", rx_r, ~one);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule